// File: doc/BRIEF.md
# Non-blocking load miss tracker

This block sits between a data cache and a pipelined system bus. It keeps a small table of load misses that are still outstanding. A new miss can therefore start its own bus read while older refills are still waiting for data, so the cache does not block on the first miss. Each accepted miss takes a free table slot. The slot index also serves as the bus transaction ID. The slot drives a line read on the address channel, gathers the four returning data beats that carry its ID, and then hands the complete line and the tag of the load that caused it to the cache fill path.

A miss to a line that a slot already tracks does not start a second bus read. It is accepted at once and reported as a hit on that pending slot, so that external folding logic can attach the load to the refill already in flight. A miss to a new line stalls the requester only when every slot is occupied.

Each slot runs a four-state machine:
- FREE goes to ISSUE when the slot is allocated.
- ISSUE goes to DATA when its address phase is granted.
- DATA goes to FILL when the fourth beat arrives.
- FILL goes back to FREE after one cycle.

The address channel has a two-state machine:
- IDLE goes to DRIVE when any slot is in ISSUE.
- DRIVE stays in DRIVE while the bus has not accepted the address. On acceptance it moves straight to the next waiting slot. When no slot is waiting, it returns to IDLE.

Top module: `miss_tracker`

## Requirements
- R1: After reset, `req_ready` is 1. `addr_valid`, `fill_valid` and `fold_hit` are 0.
- R2: A miss to a line that no slot tracks is accepted while a slot is free. If the bus accepts at once, its address phase (`addr_line` = the requested line, `addr_id` = the slot index) appears in the second cycle after acceptance.
- R3: At most NUM_ENT (6) misses are outstanding. While all slots are busy, a miss to an untracked line sees `req_ready` = 0 and waits. It is accepted in the cycle after a slot's fill pulse.
- R4: Later misses issue while earlier ones still wait for data. Misses accepted in consecutive cycles, with the bus always accepting, give address phases in consecutive cycles.
- R5: While `addr_valid` is 1 and `addr_ack` is 0, `addr_line` and `addr_id` hold. Each cycle of stall delays the address phase by one cycle.
- R6: A beat with `dbeat_id` = k goes to slot k. Beat number j (0 to 3, in arrival order) occupies `fill_data[64*j +: 64]`.
- R7: In the cycle after a slot's fourth beat, `fill_valid` pulses for one cycle with that slot's line, original tag and data. The slot is then free.
- R8: A miss to a line held by a slot in ISSUE or DATA raises `fold_hit` with `fold_id` = that slot. It is accepted even when all slots are busy, starts no bus read and causes no extra fill.
- R9: With a memory that delivers the first beat 10 cycles after the address phase and needs 5 cycles per line on the data bus, six back-to-back misses complete exactly 5 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_line | input | ADDR_W | Line address of the miss |
| req_tag | input | TAG_W | Destination tag of the missing load |
| req_ready | output | 1 | Miss accepted this cycle if valid |
| fold_hit | output | 1 | Miss matches a pending slot |
| fold_id | output | ID_W | Slot that the miss matches |
| addr_valid | output | 1 | Address phase driven |
| addr_line | output | ADDR_W | Line address of the read |
| addr_id | output | ID_W | Transaction ID (slot index) |
| addr_ack | input | 1 | Bus accepts the address phase |
| dbeat_valid | input | 1 | Data beat present |
| dbeat_id | input | ID_W | Transaction ID of the beat |
| dbeat_data | input | BEAT_W | Beat payload |
| fill_valid | output | 1 | Completed line pulse |
| fill_id | output | ID_W | Slot that completed |
| fill_line | output | ADDR_W | Line address of the fill |
| fill_tag | output | TAG_W | Tag of the miss that allocated the slot |
| fill_data | output | BEATS*BEAT_W | Assembled line |

## Verification
The assertions check four rules on every cycle:
- allocations and grants land only on slots in the right state;
- beats are never routed to a slot outside DATA, and a fill is always followed by release;
- the address phase holds while stalled;
- no two pending slots track the same line, and at most one fill pulse occurs per cycle.

Only the directed scenarios can show the cycle-exact timing: address placement after acceptance, stall and resumption when the table is full, overlap of later address phases with earlier refills, and the 5-cycle spacing of fills. They also show that fill data lands in beat order and that a folded miss produces no second bus read.

// File: rtl/mt_pkg.sv
package mt_pkg;
    typedef enum logic [1:0] {
        E_FREE,
        E_ISSUE,
        E_DATA,
        E_FILL
    } ent_state_t;

    typedef enum logic {
        ISS_IDLE,
        ISS_DRIVE
    } iss_state_t;
endpackage

// File: rtl/mt_entry.sv
module mt_entry
    import mt_pkg::*;
#(
    parameter int ADDR_W = 27,
    parameter int TAG_W  = 6,
    parameter int BEAT_W = 64,
    parameter int BEATS  = 4,
    parameter int ID_W   = 3,
    parameter int MY_ID  = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_i,
    input  logic [ADDR_W-1:0]       alloc_line_i,
    input  logic [TAG_W-1:0]        alloc_tag_i,
    input  logic                    grant_i,
    input  logic                    beat_valid_i,
    input  logic [ID_W-1:0]         beat_id_i,
    input  logic [BEAT_W-1:0]       beat_data_i,
    output logic                    free_o,
    output logic                    waiting_o,
    output logic                    busy_o,
    output logic                    fill_o,
    output logic [ADDR_W-1:0]       line_o,
    output logic [TAG_W-1:0]        tag_o,
    output logic [BEATS*BEAT_W-1:0] data_o
);
    localparam int CNT_W     = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int LINE_BITS = BEATS * BEAT_W;

    ent_state_t           st_q, st_d;
    logic [CNT_W-1:0]     cnt_q;
    logic [ADDR_W-1:0]    line_q;
    logic [TAG_W-1:0]     tag_q;
    logic [LINE_BITS-1:0] data_q;
    logic                 id_match, beat_hit, last_beat;

    assign id_match  = beat_valid_i && (beat_id_i == ID_W'(MY_ID));
    assign beat_hit  = id_match && (st_q == E_DATA);
    assign last_beat = beat_hit && (cnt_q == CNT_W'(BEATS - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= E_FREE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            E_FREE:  if (alloc_i)   st_d = E_ISSUE;
            E_ISSUE: if (grant_i)   st_d = E_DATA;
            E_DATA:  if (last_beat) st_d = E_FILL;
            E_FILL:                 st_d = E_FREE;
            default:                st_d = E_FREE;
        endcase
    end

    // outputs
    always_comb begin
        free_o    = (st_q == E_FREE);
        waiting_o = (st_q == E_ISSUE);
        busy_o    = (st_q == E_ISSUE) || (st_q == E_DATA);
        fill_o    = (st_q == E_FILL);
        line_o    = line_q;
        tag_o     = tag_q;
        data_o    = data_q;
    end

    // line buffer and beat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            line_q <= '0;
            tag_q  <= '0;
            data_q <= '0;
        end else if (alloc_i) begin
            cnt_q  <= '0;
            line_q <= alloc_line_i;
            tag_q  <= alloc_tag_i;
        end else if (beat_hit) begin
            data_q[int'(cnt_q)*BEAT_W +: BEAT_W] <= beat_data_i;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r3_alloc_free: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> st_q == E_FREE);
    a_r2_grant_issue: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |-> st_q == E_ISSUE);
    a_r6_beat_owner: assert property (@(posedge clk) disable iff (!rst_n)
        id_match |-> st_q == E_DATA);
    a_r7_fill_release: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == E_FILL |=> st_q == E_FREE);
endmodule

// File: rtl/mt_issue.sv
module mt_issue
    import mt_pkg::*;
#(
    parameter int N    = 6,
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    wait_vec,
    input  logic            ack_i,
    output logic            addr_valid_o,
    output logic [ID_W-1:0] sel_o,
    output logic [N-1:0]    grant_o
);
    iss_state_t      st_q, st_d;
    logic [ID_W-1:0] sel_q, sel_d;
    logic [ID_W-1:0] pick_all, pick_oth;
    logic [N-1:0]    others;

    assign others = wait_vec & ~(N'(1) << sel_q);

    always_comb begin
        pick_all = '0;
        pick_oth = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (wait_vec[i]) pick_all = ID_W'(i);
            if (others[i])   pick_oth = ID_W'(i);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ISS_IDLE;
            sel_q <= '0;
        end else begin
            st_q  <= st_d;
            sel_q <= sel_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        sel_d = sel_q;
        unique case (st_q)
            ISS_IDLE: begin
                if (|wait_vec) begin
                    st_d  = ISS_DRIVE;
                    sel_d = pick_all;
                end
            end
            ISS_DRIVE: begin
                if (ack_i) begin
                    if (|others) sel_d = pick_oth;
                    else         st_d  = ISS_IDLE;
                end
            end
            default: st_d = ISS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        addr_valid_o = (st_q == ISS_DRIVE);
        sel_o        = sel_q;
        grant_o      = (st_q == ISS_DRIVE && ack_i) ? (N'(1) << sel_q) : '0;
    end

    a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && !ack_i) |=> (addr_valid_o && $stable(sel_o)));
    a_r4_sel_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_o |-> wait_vec[sel_q]);
endmodule

// File: rtl/mt_alloc.sv
module mt_alloc #(
    parameter int N      = 6,
    parameter int ADDR_W = 27,
    parameter int ID_W   = 3
) (
    input  logic [N-1:0]      busy_vec,
    input  logic [N-1:0]      free_vec,
    input  logic [ADDR_W-1:0] ent_line [N],
    input  logic [ADDR_W-1:0] req_line,
    output logic              match_o,
    output logic [ID_W-1:0]   match_id_o,
    output logic              free_any_o,
    output logic [N-1:0]      alloc_pick_o
);
    always_comb begin
        match_o      = 1'b0;
        match_id_o   = '0;
        free_any_o   = 1'b0;
        alloc_pick_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (busy_vec[i] && ent_line[i] == req_line) begin
                match_o    = 1'b1;
                match_id_o = ID_W'(i);
            end
            if (free_vec[i]) begin
                free_any_o   = 1'b1;
                alloc_pick_o = N'(1) << i;
            end
        end
    end
endmodule

// File: rtl/miss_tracker.sv
module miss_tracker #(
    parameter int NUM_ENT = 6,
    parameter int ADDR_W  = 27,
    parameter int TAG_W   = 6,
    parameter int BEAT_W  = 64,
    parameter int BEATS   = 4,
    parameter int ID_W    = $clog2(NUM_ENT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_line,
    input  logic [TAG_W-1:0]        req_tag,
    output logic                    req_ready,
    output logic                    fold_hit,
    output logic [ID_W-1:0]         fold_id,
    output logic                    addr_valid,
    output logic [ADDR_W-1:0]       addr_line,
    output logic [ID_W-1:0]         addr_id,
    input  logic                    addr_ack,
    input  logic                    dbeat_valid,
    input  logic [ID_W-1:0]         dbeat_id,
    input  logic [BEAT_W-1:0]       dbeat_data,
    output logic                    fill_valid,
    output logic [ID_W-1:0]         fill_id,
    output logic [ADDR_W-1:0]       fill_line,
    output logic [TAG_W-1:0]        fill_tag,
    output logic [BEATS*BEAT_W-1:0] fill_data
);
    localparam int LINE_BITS = BEATS * BEAT_W;

    logic [NUM_ENT-1:0]   free_vec, wait_vec, busy_vec, fill_vec;
    logic [NUM_ENT-1:0]   alloc_vec, alloc_pick, grant_vec;
    logic [ADDR_W-1:0]    ent_line [NUM_ENT];
    logic [TAG_W-1:0]     ent_tag  [NUM_ENT];
    logic [LINE_BITS-1:0] ent_data [NUM_ENT];
    logic                 match, free_any;
    logic [ID_W-1:0]      match_id;

    mt_alloc #(.N(NUM_ENT), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_alloc (
        .busy_vec     (busy_vec),
        .free_vec     (free_vec),
        .ent_line     (ent_line),
        .req_line     (req_line),
        .match_o      (match),
        .match_id_o   (match_id),
        .free_any_o   (free_any),
        .alloc_pick_o (alloc_pick)
    );

    assign req_ready = match || free_any;
    assign fold_hit  = req_valid && match;
    assign fold_id   = match_id;
    assign alloc_vec = (req_valid && !match) ? alloc_pick : '0;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        mt_entry #(
            .ADDR_W(ADDR_W), .TAG_W(TAG_W), .BEAT_W(BEAT_W),
            .BEATS(BEATS), .ID_W(ID_W), .MY_ID(g)
        ) u_ent (
            .clk          (clk),
            .rst_n        (rst_n),
            .alloc_i      (alloc_vec[g]),
            .alloc_line_i (req_line),
            .alloc_tag_i  (req_tag),
            .grant_i      (grant_vec[g]),
            .beat_valid_i (dbeat_valid),
            .beat_id_i    (dbeat_id),
            .beat_data_i  (dbeat_data),
            .free_o       (free_vec[g]),
            .waiting_o    (wait_vec[g]),
            .busy_o       (busy_vec[g]),
            .fill_o       (fill_vec[g]),
            .line_o       (ent_line[g]),
            .tag_o        (ent_tag[g]),
            .data_o       (ent_data[g])
        );
    end

    mt_issue #(.N(NUM_ENT), .ID_W(ID_W)) u_issue (
        .clk          (clk),
        .rst_n        (rst_n),
        .wait_vec     (wait_vec),
        .ack_i        (addr_ack),
        .addr_valid_o (addr_valid),
        .sel_o        (addr_id),
        .grant_o      (grant_vec)
    );

    always_comb begin
        addr_line = '0;
        for (int i = 0; i < NUM_ENT; i++)
            if (addr_id == ID_W'(i)) addr_line = ent_line[i];
    end

    always_comb begin
        fill_valid = |fill_vec;
        fill_id    = '0;
        fill_line  = '0;
        fill_tag   = '0;
        fill_data  = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (fill_vec[i]) begin
                fill_id   = ID_W'(i);
                fill_line = ent_line[i];
                fill_tag  = ent_tag[i];
                fill_data = ent_data[i];
            end
        end
    end

    a_r7_one_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fill_vec));
    a_r5_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_ack) |=> $stable(addr_line));

    always @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NUM_ENT; i++)
                for (int j = i + 1; j < NUM_ENT; j++)
                    a_r8_unique_line: assert (!(busy_vec[i] && busy_vec[j] &&
                                                ent_line[i] == ent_line[j]));
        end
    end
endmodule

// File: tb/sim_miss_tracker.sv
`timescale 1ns/1ps
module sim_miss_tracker;
    localparam int NUM_ENT = 6, ADDR_W = 27, TAG_W = 6, BEAT_W = 64, BEATS = 4;
    localparam int ID_W = 3, LINE_W = BEATS * BEAT_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [ADDR_W-1:0] req_line = '0;
    logic [TAG_W-1:0] req_tag = '0;
    logic req_ready, fold_hit, addr_valid, fill_valid;
    logic [ID_W-1:0] fold_id, addr_id, fill_id;
    logic [ADDR_W-1:0] addr_line, fill_line;
    logic addr_ack = 1'b0, dbeat_valid = 1'b0;
    logic [ID_W-1:0] dbeat_id = '0;
    logic [BEAT_W-1:0] dbeat_data = '0;
    logic [TAG_W-1:0] fill_tag;
    logic [LINE_W-1:0] fill_data;

    miss_tracker #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W), .TAG_W(TAG_W),
                   .BEAT_W(BEAT_W), .BEATS(BEATS), .ID_W(ID_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
        .req_tag(req_tag), .req_ready(req_ready), .fold_hit(fold_hit),
        .fold_id(fold_id), .addr_valid(addr_valid), .addr_line(addr_line),
        .addr_id(addr_id), .addr_ack(addr_ack), .dbeat_valid(dbeat_valid),
        .dbeat_id(dbeat_id), .dbeat_data(dbeat_data), .fill_valid(fill_valid),
        .fill_id(fill_id), .fill_line(fill_line), .fill_tag(fill_tag),
        .fill_data(fill_data));

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0;
    int acc_cyc [16], iss_cyc [16], fill_cyc [16], iss_id_of [16];
    logic [TAG_W-1:0] exp_tag [16];
    int issue_count = 0, fill_count = 0, hold_budget = 0;
    bit stalled_prev = 1'b0;
    logic [ADDR_W-1:0] prev_line;
    bit act [8];
    int beat_st [8];
    logic [ADDR_W-1:0] bus_line [8];
    int next_free = 0;
    logic [LINE_W-1:0] exp_data;

    task automatic chk(input bit ok, input string req, input longint act_v, input longint exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    function automatic logic [63:0] beat_val(input logic [ADDR_W-1:0] ln, input int k);
        logic [1:0] kk;
        kk = k[1:0];
        return {5'h0, ln, 30'h0, kk} ^ 64'hC3C3_0000_1234_0000;
    endfunction

    // memory model and fill monitor
    initial begin
        for (int i = 0; i < 8; i++) act[i] = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (addr_valid && hold_budget > 0) begin
                    addr_ack = 1'b0;
                    hold_budget--;
                end else addr_ack = 1'b1;
                if (addr_valid && stalled_prev)
                    chk(addr_line == prev_line, "R5 address held", addr_line, prev_line);
                stalled_prev = addr_valid && !addr_ack;
                prev_line = addr_line;
                if (addr_valid && addr_ack) begin
                    int id, s;
                    id = int'(addr_id);
                    chk(!act[id], "R2 id not in flight", act[id], 0);
                    act[id] = 1'b1;
                    bus_line[id] = addr_line;
                    s = (cyc + 10 > next_free) ? cyc + 10 : next_free;
                    beat_st[id] = s;
                    next_free = s + 5;
                    iss_cyc[addr_line[3:0]] = cyc;
                    iss_id_of[addr_line[3:0]] = id;
                    issue_count++;
                end
                dbeat_valid = 1'b0;
                for (int i = 0; i < 8; i++) begin
                    if (act[i] && cyc >= beat_st[i] && cyc <= beat_st[i] + 3) begin
                        dbeat_valid = 1'b1;
                        dbeat_id = ID_W'(i);
                        dbeat_data = beat_val(bus_line[i], cyc - beat_st[i]);
                        if (cyc == beat_st[i] + 3) act[i] = 1'b0;
                    end
                end
                if (fill_valid) begin
                    int li;
                    li = int'(fill_line[3:0]);
                    for (int k = 0; k < BEATS; k++)
                        exp_data[k*BEAT_W +: BEAT_W] = beat_val(fill_line, k);
                    chk(fill_data == exp_data, "R6 fill data order",
                        longint'(fill_data[63:0]), longint'(exp_data[63:0]));
                    chk(fill_tag == exp_tag[li], "R7 fill tag", fill_tag, exp_tag[li]);
                    fill_cyc[li] = cyc;
                    fill_count++;
                end
            end
        end
    end

    task automatic req_one(input int ln, input int tag, output bit folded, output int fid);
        @(negedge clk);
        req_valid = 1'b1;
        req_line = ADDR_W'(ln);
        req_tag = TAG_W'(tag);
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        folded = fold_hit;
        fid = int'(fold_id);
        if (!folded) begin
            exp_tag[ln] = TAG_W'(tag);
            acc_cyc[ln] = cyc;
        end
    endtask

    task automatic req_idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_fills(input int n);
        int t = 0;
        while (fill_count < n && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        chk(fill_count == n, "R7 fill count", fill_count, n);
    endtask

    task automatic t_reset();
        #1;
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(addr_valid == 1'b0, "R1 addr_valid", addr_valid, 0);
        chk(fill_valid == 1'b0, "R1 fill_valid", fill_valid, 0);
        chk(fold_hit == 1'b0, "R1 fold_hit", fold_hit, 0);
    endtask

    task automatic t_single();
        bit f; int fid; int base;
        base = fill_count;
        req_one(1, 3, f, fid);
        req_idle();
        wait_fills(base + 1);
        chk(iss_cyc[1] - acc_cyc[1] == 2, "R2 issue latency", iss_cyc[1] - acc_cyc[1], 2);
        chk(fill_cyc[1] - iss_cyc[1] == 14, "R7 fill latency", fill_cyc[1] - iss_cyc[1], 14);
    endtask

    task automatic t_burst();
        bit f; int fid; int base;
        base = fill_count;
        for (int i = 0; i < 6; i++) req_one(2 + i, 10 + i, f, fid);
        @(negedge clk);
        req_line = ADDR_W'(8);
        req_tag = TAG_W'(20);
        #1;
        chk(req_ready == 1'b0, "R3 stall when full", req_ready, 0);
        chk(fold_hit == 1'b0, "R3 no fold", fold_hit, 0);
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        exp_tag[8] = TAG_W'(20);
        acc_cyc[8] = cyc;
        req_idle();
        wait_fills(base + 7);
        for (int i = 1; i < 6; i++)
            chk(iss_cyc[2+i] == iss_cyc[1+i] + 1, "R4 back-to-back address",
                iss_cyc[2+i] - iss_cyc[1+i], 1);
        chk(iss_cyc[7] < fill_cyc[2], "R4 issue before first refill", iss_cyc[7], fill_cyc[2]);
        for (int i = 1; i < 6; i++)
            chk(fill_cyc[2+i] - fill_cyc[1+i] == 5, "R9 fill spacing",
                fill_cyc[2+i] - fill_cyc[1+i], 5);
        chk(acc_cyc[8] == fill_cyc[2] + 1, "R3 accept after release", acc_cyc[8], fill_cyc[2] + 1);
    endtask

    task automatic t_fold();
        bit f; int fid; int base, ib;
        base = fill_count;
        ib = issue_count;
        req_one(9, 1, f, fid);
        chk(f == 1'b0, "R8 first miss not folded", f, 0);
        req_one(9, 2, f, fid);
        chk(f == 1'b1, "R8 fold hit", f, 1);
        req_idle();
        wait_fills(base + 1);
        repeat (20) @(negedge clk);
        chk(issue_count == ib + 1, "R8 single bus read", issue_count, ib + 1);
        chk(fid == iss_id_of[9], "R8 fold id", fid, iss_id_of[9]);
        chk(fill_count == base + 1, "R8 no extra fill", fill_count, base + 1);
        base = fill_count;
        ib = issue_count;
        for (int i = 10; i < 16; i++) req_one(i, i, f, fid);
        @(negedge clk);
        req_line = ADDR_W'(12);
        req_tag = TAG_W'(30);
        #1;
        chk(fold_hit == 1'b1, "R8 fold when full", fold_hit, 1);
        chk(req_ready == 1'b1, "R8 ready when full", req_ready, 1);
        @(negedge clk);
        req_line = ADDR_W'(1);
        #1;
        chk(req_ready == 1'b0, "R3 new line stalls", req_ready, 0);
        req_valid = 1'b0;
        wait_fills(base + 6);
        chk(issue_count == ib + 6, "R8 no read for fold", issue_count, ib + 6);
    endtask

    task automatic t_hold();
        bit f; int fid; int base;
        base = fill_count;
        hold_budget = 3;
        req_one(0, 5, f, fid);
        req_idle();
        wait_fills(base + 1);
        chk(iss_cyc[0] - acc_cyc[0] == 5, "R5 stalled issue", iss_cyc[0] - acc_cyc[0], 5);
        chk(fill_cyc[0] - iss_cyc[0] == 14, "R7 fill after stall", fill_cyc[0] - iss_cyc[0], 14);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_burst();
        t_fold();
        t_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule